// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder

This block converts the logic-level commands for a single H-bridge into four gate enables: a high-side and a low-side switch for each of the bridge's two output legs. A scheme-select input picks how the two command inputs are read. In the direct scheme each command input steers one leg. In the steering scheme one input gives the rotation sense and the other enables the bridge. Each leg is either pulled high, pulled low or left floating.

Whenever a leg hands over from its high-side switch to its low-side switch, or the reverse, both switches of that leg are held off for a programmable number of clock cycles before the new switch turns on. A leg that leaves or enters the floating state changes at once. A bridge-kill input from a fault supervisor in the same clock domain forces all four switches off on the next clock edge, cancelling any handover in progress. The three command inputs cross into the clock domain through a synchronizer chain before they are decoded.

Top module: `hbridge_gate_decoder`

## Requirements
- R1: While reset is asserted and after its release with all inputs low, all four gate enables are 0. The synchronizer resets to 0, so an undriven or low scheme-select input selects the direct scheme.
- R2: Direct scheme (scheme_sel=0) with cmd_a=0 and cmd_b=0 leaves both legs floating: all four gate enables are 0 (coast).
- R3: Direct scheme with cmd_a=1, cmd_b=0 drives leg 1 high and leg 2 low; with cmd_a=0, cmd_b=1 it drives leg 1 low and leg 2 high.
- R4: Direct scheme with cmd_a=1 and cmd_b=1 drives both legs low (brake).
- R5: Steering scheme (scheme_sel=1) with cmd_b (enable)=0 drives both legs low, whatever cmd_a (sense) is.
- R6: Steering scheme with cmd_b=1: cmd_a=1 drives leg 1 low and leg 2 high; cmd_a=0 drives leg 1 high and leg 2 low.
- R7: The high-side and low-side enables of one leg are never 1 in the same cycle.
- R8: When a leg goes from driven high to driven low or the reverse, both of its enables are 0 for exactly DEAD_CYCLES clock cycles, after which the newly requested switch turns on.
- R9: A leg that goes from floating to driven, or from driven to floating, changes on the same edge as any other decoded update, with no dead-time wait.
- R10: bridge_kill=1 sampled on a rising edge forces all four enables to 0 after that edge, overriding any dead-time interval; after release the legs leave the floating state without dead time.
- R11: If a leg's request changes to the other driven level during its dead-time interval, the interval restarts at full length and the leg targets the newest request.
- R12: A change on scheme_sel, cmd_a or cmd_b first shows at the gate enables after the third rising edge following it (SYNC_STAGES=2 synchronizer flops plus the leg register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scheme_sel | input | 1 | 0 = direct scheme, 1 = steering scheme |
| cmd_a | input | 1 | Leg 1 command (direct) or sense (steering) |
| cmd_b | input | 1 | Leg 2 command (direct) or enable (steering) |
| bridge_kill | input | 1 | Synchronous fault kill, forces all switches off |
| leg1_hs | output | 1 | Leg 1 high-side gate enable |
| leg1_ls | output | 1 | Leg 1 low-side gate enable |
| leg2_hs | output | 1 | Leg 2 high-side gate enable |
| leg2_ls | output | 1 | Leg 2 low-side gate enable |

## Verification
Command changes reach the gate enables three rising edges after they are applied, a dead-time handover keeps a leg dark for DEAD_CYCLES cycles after that, and a kill takes effect one edge after it is sampled. The bench's reference model carries the two-deep synchronizer as a queue of input samples and advances the leg model on every rising edge, so its prediction already sits in the cycle where the design's registered outputs change. Outputs are compared on every falling edge, and the three-edge latency is also probed directly by checking the enables are unchanged after two edges and changed after the third.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

   typedef enum logic [1:0] {
      LEG_FLOAT = 2'd0,
      LEG_LOW   = 2'd1,
      LEG_HIGH  = 2'd2
   } leg_state_e;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbg_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hbg_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= async_in;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
   import hbg_pkg::*;
(
   input  logic       scheme,
   input  logic       sig_a,
   input  logic       sig_b,
   output leg_state_e want1,
   output leg_state_e want2
);

   always_comb begin
      want1 = LEG_FLOAT;
      want2 = LEG_FLOAT;
      if (!scheme) begin
         unique case ({sig_a, sig_b})
            2'b00: begin want1 = LEG_FLOAT; want2 = LEG_FLOAT; end
            2'b10: begin want1 = LEG_HIGH;  want2 = LEG_LOW;   end
            2'b01: begin want1 = LEG_LOW;   want2 = LEG_HIGH;  end
            default: begin want1 = LEG_LOW; want2 = LEG_LOW;   end
         endcase
      end else begin
         if (!sig_b) begin
            want1 = LEG_LOW;
            want2 = LEG_LOW;
         end else if (sig_a) begin
            want1 = LEG_LOW;
            want2 = LEG_HIGH;
         end else begin
            want1 = LEG_HIGH;
            want2 = LEG_LOW;
         end
      end
   end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
   import hbg_pkg::*;
#(
   parameter int DEAD_CYCLES = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       kill,
   input  leg_state_e target,
   output logic       gate_hs,
   output logic       gate_ls
);

   localparam int CNT_W = $clog2(DEAD_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   generate
      if (DEAD_CYCLES < 1) begin : g_bad_dead
         $error("hbg_leg: DEAD_CYCLES must be at least 1");
      end
   endgenerate

   leg_state_e       drive_q;
   leg_state_e       pend_q;
   logic [CNT_W-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= LEG_FLOAT;
         pend_q  <= LEG_FLOAT;
         gap_q   <= '0;
      end else if (kill) begin
         drive_q <= LEG_FLOAT;
         pend_q  <= LEG_FLOAT;
         gap_q   <= '0;
      end else if (gap_q != '0) begin
         if (target == LEG_FLOAT) begin
            drive_q <= LEG_FLOAT;
            gap_q   <= '0;
         end else if (target != pend_q) begin
            pend_q <= target;
            gap_q  <= CNT_LOAD;
         end else if (gap_q == CNT_ONE) begin
            drive_q <= pend_q;
            gap_q   <= '0;
         end else begin
            gap_q <= gap_q - CNT_ONE;
         end
      end else if (target != drive_q) begin
         if (target == LEG_FLOAT || drive_q == LEG_FLOAT) begin
            drive_q <= target;
         end else begin
            drive_q <= LEG_FLOAT;
            pend_q  <= target;
            gap_q   <= CNT_LOAD;
         end
      end
   end

   assign gate_hs = (drive_q == LEG_HIGH);
   assign gate_ls = (drive_q == LEG_LOW);

   // R7: one leg never conducts through both switches
   assert_no_shoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hs && gate_ls));

   // R8: a high-side on-cycle is never followed directly by a low-side one
   assert_gap_hi_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_hs |=> !gate_ls);

   assert_gap_lo_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_ls |=> !gate_hs);

   // R8: while the dead-time counter runs the leg stays dark
   assert_dark_in_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q != '0) |-> (!gate_hs && !gate_ls));

   assert_gap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= CNT_LOAD);

   // R10: kill empties the leg on the next edge
   assert_kill_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!gate_hs && !gate_ls && gap_q == '0));

endmodule

// File: rtl/hbridge_gate_decoder.sv
module hbridge_gate_decoder
   import hbg_pkg::*;
#(
   parameter int DEAD_CYCLES = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scheme_sel,
   input  logic cmd_a,
   input  logic cmd_b,
   input  logic bridge_kill,
   output logic leg1_hs,
   output logic leg1_ls,
   output logic leg2_hs,
   output logic leg2_ls
);

   localparam int N_LEGS = 2;
   localparam int N_CMD  = 3;

   logic [N_CMD-1:0] cmd_sync;
   leg_state_e       want [N_LEGS];
   logic [N_LEGS-1:0] hs_en;
   logic [N_LEGS-1:0] ls_en;

   hbg_sync #(
      .WIDTH  (N_CMD),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({scheme_sel, cmd_a, cmd_b}),
      .sync_out (cmd_sync)
   );

   hbg_decode u_decode (
      .scheme (cmd_sync[2]),
      .sig_a  (cmd_sync[1]),
      .sig_b  (cmd_sync[0]),
      .want1  (want[0]),
      .want2  (want[1])
   );

   generate
      for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
         hbg_leg #(
            .DEAD_CYCLES (DEAD_CYCLES)
         ) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill    (bridge_kill),
            .target  (want[g]),
            .gate_hs (hs_en[g]),
            .gate_ls (ls_en[g])
         );
      end
   endgenerate

   assign leg1_hs = hs_en[0];
   assign leg1_ls = ls_en[0];
   assign leg2_hs = hs_en[1];
   assign leg2_ls = ls_en[1];

   // R10: kill darkens the whole bridge after one edge
   assert_bridge_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bridge_kill |=> (hs_en == '0 && ls_en == '0));

   // R9/R2: a floating request never has a leg switched on after the kill is held
   assert_kill_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bridge_kill && $past(bridge_kill)) |-> (hs_en == '0 && ls_en == '0));

endmodule

// File: tb/hbridge_gate_decoder_bench.sv
module hbridge_gate_decoder_bench;

   localparam int DEAD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scheme_sel = 1'b0;
   logic cmd_a = 1'b0;
   logic cmd_b = 1'b0;
   logic bridge_kill = 1'b0;
   logic leg1_hs, leg1_ls, leg2_hs, leg2_ls;

   int vectors = 0;
   int miscompares = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #5 clk = ~clk;

   hbridge_gate_decoder #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) u_hbridge_gate_decoder (
      .clk(clk), .rst_n(rst_n), .scheme_sel(scheme_sel), .cmd_a(cmd_a), .cmd_b(cmd_b),
      .bridge_kill(bridge_kill), .leg1_hs(leg1_hs), .leg1_ls(leg1_ls),
      .leg2_hs(leg2_hs), .leg2_ls(leg2_ls));

   // reference model: 0 float, 1 low, 2 high
   int m_drv [2];
   int m_pend [2];
   int m_cnt [2];
   logic [2:0] hist [$];

   function automatic int want_of(input logic [2:0] v, input int leg);
      logic md, a, b;
      {md, a, b} = v;
      if (!md) begin
         if (a && b) return 1;
         if (!a && !b) return 0;
         if (leg == 0) return a ? 2 : 1;
         return b ? 2 : 1;
      end
      if (!b) return 1;
      if (leg == 0) return a ? 1 : 2;
      return a ? 2 : 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin m_drv[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; end
         hist.delete();
         hist.push_back(3'b000);
         hist.push_back(3'b000);
      end else begin
         logic [2:0] seen;
         seen = hist.pop_front();
         for (int i = 0; i < 2; i++) begin
            int t;
            t = want_of(seen, i);
            if (bridge_kill) begin
               m_drv[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
            end else if (m_cnt[i] > 0) begin
               if (t == 0) begin m_drv[i] = 0; m_cnt[i] = 0; end
               else if (t != m_pend[i]) begin m_pend[i] = t; m_cnt[i] = DEAD; end
               else begin
                  m_cnt[i]--;
                  if (m_cnt[i] == 0) m_drv[i] = m_pend[i];
               end
            end else if (t != m_drv[i]) begin
               if (t == 0 || m_drv[i] == 0) m_drv[i] = t;
               else begin m_drv[i] = 0; m_pend[i] = t; m_cnt[i] = DEAD; end
            end
         end
         hist.push_back({scheme_sel, cmd_a, cmd_b});
      end
   end

   always @(negedge clk) begin
      logic [3:0] got, exp;
      got = {leg1_hs, leg1_ls, leg2_hs, leg2_ls};
      exp = {m_drv[0] == 2, m_drv[0] == 1, m_drv[1] == 2, m_drv[1] == 1};
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: gates actual %b expected %b at %0t", cur_req, got, exp, $time);
      end
      if ((leg1_hs && leg1_ls) || (leg2_hs && leg2_ls)) begin
         miscompares++;
         $display("FAIL R7: shoot-through actual %b expected no leg with both on", got);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %b expected %b", req, got, exp);
      end
   endtask

   task automatic apply(input logic md, input logic a, input logic b);
      scheme_sel = md; cmd_a = a; cmd_b = b;
   endtask

   function automatic logic [3:0] gates();
      return {leg1_hs, leg1_ls, leg2_hs, leg2_ls};
   endfunction

   initial begin
      cur_req = "R1";
      step(3);
      check("R1", gates(), 4'b0000);
      rst_n = 1'b1;
      step(5);
      check("R1", gates(), 4'b0000);

      cur_req = "R2";
      apply(0, 0, 0);
      step(6);
      check("R2", gates(), 4'b0000);

      // R12 latency probe, R9 float to driven without wait, R3 forward
      cur_req = "R12";
      @(negedge clk);
      apply(0, 1, 0);
      step(2);
      check("R12", gates(), 4'b0000);
      step(1);
      check("R12", gates(), 4'b1001);
      cur_req = "R3";
      step(4);
      check("R3", gates(), 4'b1001);

      // R3 reverse with R8 handover on both legs
      cur_req = "R8";
      apply(0, 0, 1);
      step(4);
      check("R8", gates(), 4'b0000);
      step(DEAD - 2);
      check("R8", gates(), 4'b0000);
      step(1);
      check("R3", gates(), 4'b0110);
      step(3);

      cur_req = "R4";
      apply(0, 1, 1);
      step(DEAD + 6);
      check("R4", gates(), 4'b0101);

      cur_req = "R9";
      apply(0, 0, 0);
      step(3);
      check("R9", gates(), 4'b0000);
      apply(0, 1, 1);
      step(3);
      check("R9", gates(), 4'b0101);

      cur_req = "R5";
      apply(1, 0, 0);
      step(5);
      check("R5", gates(), 4'b0101);
      apply(1, 1, 0);
      step(5);
      check("R5", gates(), 4'b0101);

      cur_req = "R6";
      apply(1, 0, 1);
      step(DEAD + 6);
      check("R6", gates(), 4'b1001);
      apply(1, 1, 1);
      step(DEAD + 6);
      check("R6", gates(), 4'b0110);

      // R11: reversal halfway through the gap restarts it
      cur_req = "R11";
      apply(1, 0, 1);
      step(3 + 4);
      check("R11", gates(), 4'b0000);
      apply(1, 1, 1);
      step(3 + DEAD - 2);
      check("R11", gates(), 4'b0000);
      step(2);
      check("R11", gates(), 4'b0110);

      // R10: kill during a handover, then release
      cur_req = "R10";
      apply(1, 0, 1);
      step(5);
      bridge_kill = 1'b1;
      step(1);
      check("R10", gates(), 4'b0000);
      step(DEAD + 4);
      check("R10", gates(), 4'b0000);
      bridge_kill = 1'b0;
      step(1);
      check("R10", gates(), 4'b1001);
      bridge_kill = 1'b1;
      step(1);
      check("R10", gates(), 4'b0000);
      bridge_kill = 1'b0;
      apply(0, 0, 0);
      step(6);
      check("R2", gates(), 4'b0000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule